// File: doc/BRIEF.md
# Receive Queue with Automatic RTS Flow Control

This block sits between the receive deserializer of one UART channel and the CPU-facing register logic. Each received character arrives as a one-cycle valid strobe carrying eight data bits and three error flags. The block queues the character and its flags in a 64-entry first-in first-out store. The CPU pops them one at a time with a read strobe.

Around the queue the block raises three kinds of request. A trigger-level flag follows the queue fill live against a selectable threshold. A character-timeout request tells the CPU that a few characters are sitting idle below the threshold. An interrupt request combines the two. An active-low RTS output, when automatic flow control is enabled, tells the remote transmitter to pause once the queue reaches the threshold. It resumes the remote side only after the queue has drained by a selectable hysteresis margin. The current fill can be shown on a count output when the count view is selected.

Top module: `rxq_flow`

## Requirements
- R1: Characters are returned in arrival order, each with the three error bits it arrived with; `rd_data`/`rd_err` take the popped entry on the clock edge that samples `rd_en` high while the queue is non-empty.
- R2: The fill level runs from 0 to 64. `cnt_out` equals the fill level when `cnt_show` is 1 and is 0 when `cnt_show` is 0.
- R3: `trig_sel` values 0, 1, 2 and 3 select thresholds of 8, 16, 56 and 60 entries. `trig_hit` is 1 whenever the fill level is at or above the selected threshold, including straight after `trig_sel` changes.
- R4: `trig_hit` returns to 0 in the same cycle that the fill level drops below the threshold. It does not wait for any read of status.
- R5: A character that arrives while the queue holds 64 entries is discarded and the level stays 64. `ovr_flag` is then set and stays set until the next read of a non-empty queue clears it.
- R6: A read of an empty queue leaves `rd_data`, `rd_err` and the fill level unchanged.
- R7: `tmo_req` rises once the queue is non-empty and 4 `char_tick` pulses have passed with no receive strobe and no read of a non-empty queue. Any such strobe or read clears it, and an empty queue never requests.
- R8: `rx_irq` is 1 exactly when `trig_hit` or `tmo_req` is 1.
- R9: With `arts_en` = 1, `rts_n` goes high on the clock edge after the fill level reaches the threshold.
- R10: After rising, `rts_n` stays high until the fill level is at or below the threshold minus the hysteresis. `hyst_sel` values 0, 1, 2 and 3 select a hysteresis of 0, 4, 6 and 8 entries. `rts_n` then goes low on the following edge.
- R11: With `arts_en` = 0, `rts_n` is low one edge later, whatever the fill level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received character |
| rx_err | input | 3 | Error flags of the received character |
| rd_en | input | 1 | CPU pop strobe |
| rd_data | output | 8 | Last popped character |
| rd_err | output | 3 | Error flags of the last popped character |
| trig_sel | input | 2 | Threshold select: 8, 16, 56, 60 |
| hyst_sel | input | 2 | RTS hysteresis select: 0, 4, 6, 8 |
| arts_en | input | 1 | Automatic RTS enable |
| char_tick | input | 1 | One pulse per character time |
| cnt_show | input | 1 | Count view select |
| cnt_out | output | 7 | Fill level when count view is selected, else 0 |
| trig_hit | output | 1 | Fill level at or above the threshold |
| tmo_req | output | 1 | Character-timeout request |
| rx_irq | output | 1 | Interrupt request: threshold or timeout |
| ovr_flag | output | 1 | Overrun: a character was discarded |
| rts_n | output | 1 | Active-low request-to-send |

## Verification
A corrupted pointer or level counter shows up at once: on the next pop, `rd_data` no longer matches the arrival order, and `cnt_out` drifts from the number of pushes minus pops. A bad threshold or hysteresis decode shows on `trig_hit` in the same cycle as the level change, and on `rts_n` one edge later, so the bench walks the level across each boundary in single steps. The timeout counter is visible only through `tmo_req`. It is therefore tested at exactly 3 and 4 ticks, and again after each kind of activity that should restart it.

// File: rtl/rxq_pkg.sv
// Shared definitions for the receive queue.
// Assumes three error flags per character and an 8-bit character.
package rxq_pkg;
    localparam int unsigned RXQ_DW = 8;
    localparam int unsigned RXQ_EW = 3;

    typedef struct packed {
        logic [RXQ_EW-1:0] err;
        logic [RXQ_DW-1:0] data;
    } rxq_word_t;

    // Hysteresis margin selected by the 2-bit field.
    function automatic int unsigned hyst_of(input logic [1:0] sel);
        case (sel)
            2'd0:    return 0;
            2'd1:    return 4;
            2'd2:    return 6;
            default: return 8;
        endcase
    endfunction

    // Threshold selected by the 2-bit field, relative to queue depth.
    function automatic int unsigned trig_of(input logic [1:0] sel, input int unsigned depth);
        case (sel)
            2'd0:    return depth / 8;
            2'd1:    return depth / 4;
            2'd2:    return depth - 8;
            default: return depth - 4;
        endcase
    endfunction
endpackage

// File: rtl/rxq_store.sv
// Circular store of received words with a fill level counter.
// Assumes DEPTH is a power of two so that the pointers wrap naturally.
// A write into a full store is dropped and raises a sticky overrun flag
// that the next successful pop clears. A pop of an empty store changes nothing.
module rxq_store
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = $clog2(DEPTH),
    localparam int unsigned CW = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_req,
    input  rxq_word_t       wr_word,
    input  logic            rd_req,
    output rxq_word_t       rd_word,
    output logic            rd_ok,
    output logic [CW-1:0]   level,
    output logic            ovr
);
    rxq_word_t       mem [DEPTH];
    logic [AW-1:0]   wptr, rptr;
    logic            full, empty, wr_ok;

    assign full  = (level == CW'(DEPTH));
    assign empty = (level == '0);
    assign wr_ok = wr_req && !full;
    assign rd_ok = rd_req && !empty;

    // Store the incoming word at the write pointer.
    always_ff @(posedge clk) begin
        if (wr_ok) mem[wptr] <= wr_word;
    end

    // Advance pointers and level, and capture the popped word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            rptr    <= '0;
            level   <= '0;
            rd_word <= '0;
        end else begin
            if (wr_ok) wptr <= wptr + 1'b1;
            if (rd_ok) begin
                rptr    <= rptr + 1'b1;
                rd_word <= mem[rptr];
            end
            level <= level + CW'(wr_ok) - CW'(rd_ok);
        end
    end

    // Sticky overrun: set by a dropped write, cleared by a pop.
    always_ff @(posedge clk) begin
        if (!rst_n)              ovr <= 1'b0;
        else if (wr_req && full) ovr <= 1'b1;
        else if (rd_ok)          ovr <= 1'b0;
    end
endmodule

// File: rtl/rxq_timeout.sv
// Counts character-time ticks since the last queue activity and requests
// service after LIMIT idle character times while the queue holds data.
// Assumes activity and tick are single-cycle pulses in the clock domain.
module rxq_timeout #(
    parameter int unsigned LIMIT = 4,
    localparam int unsigned TW = $clog2(LIMIT + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic activity,
    input  logic tick,
    input  logic nonempty,
    output logic req
);
    logic [TW-1:0] idle;

    // Restart on activity or empty queue, otherwise count ticks up to LIMIT.
    always_ff @(posedge clk) begin
        if (!rst_n)                               idle <= '0;
        else if (activity || !nonempty)           idle <= '0;
        else if (tick && idle != TW'(LIMIT))      idle <= idle + 1'b1;
    end

    assign req = nonempty && (idle == TW'(LIMIT));
endmodule

// File: rtl/rxq_rts.sv
// Automatic RTS with hysteresis: deasserts (high) at the threshold and
// reasserts (low) once the level falls to threshold minus margin.
// Assumes margin never exceeds threshold. Held low while disabled.
module rxq_rts #(
    parameter int unsigned CW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic [CW-1:0] level,
    input  logic [CW-1:0] trig,
    input  logic [CW-1:0] hyst,
    output logic          rts_n
);
    logic [CW-1:0] low_mark;

    assign low_mark = trig - hyst;

    // Hysteretic RTS state update.
    always_ff @(posedge clk) begin
        if (!rst_n)                rts_n <= 1'b0;
        else if (!en)              rts_n <= 1'b0;
        else if (level >= trig)    rts_n <= 1'b1;
        else if (level <= low_mark) rts_n <= 1'b0;
    end
endmodule

// File: rtl/rxq_flow.sv
// Receive queue of one UART channel with threshold status, character
// timeout, overrun flag and automatic RTS flow control.
// Assumes DEPTH is a power of two and at least 64, so that every threshold
// is at least the largest hysteresis margin.
module rxq_flow
    import rxq_pkg::*;
#(
    parameter int unsigned DEPTH    = 64,
    parameter int unsigned TO_CHARS = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rx_valid,
    input  logic [7:0]                    rx_data,
    input  logic [2:0]                    rx_err,
    input  logic                          rd_en,
    output logic [7:0]                    rd_data,
    output logic [2:0]                    rd_err,
    input  logic [1:0]                    trig_sel,
    input  logic [1:0]                    hyst_sel,
    input  logic                          arts_en,
    input  logic                          char_tick,
    input  logic                          cnt_show,
    output logic [$clog2(DEPTH+1)-1:0]    cnt_out,
    output logic                          trig_hit,
    output logic                          tmo_req,
    output logic                          rx_irq,
    output logic                          ovr_flag,
    output logic                          rts_n
);
    localparam int unsigned CW = $clog2(DEPTH + 1);

    rxq_word_t       in_word, out_word;
    logic [CW-1:0]   level, trig_lvl, hyst_lvl;
    logic            rd_ok;

    assign in_word = '{err: rx_err, data: rx_data};
    assign rd_data = out_word.data;
    assign rd_err  = out_word.err;

    // Decode threshold and hysteresis selections.
    always_comb begin
        trig_lvl = CW'(trig_of(trig_sel, DEPTH));
        hyst_lvl = CW'(hyst_of(hyst_sel));
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_req  (rx_valid),
        .wr_word (in_word),
        .rd_req  (rd_en),
        .rd_word (out_word),
        .rd_ok   (rd_ok),
        .level   (level),
        .ovr     (ovr_flag)
    );

    rxq_timeout #(.LIMIT(TO_CHARS)) u_tmo (
        .clk      (clk),
        .rst_n    (rst_n),
        .activity (rx_valid || rd_ok),
        .tick     (char_tick),
        .nonempty (level != '0),
        .req      (tmo_req)
    );

    rxq_rts #(.CW(CW)) u_rts (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (arts_en),
        .level (level),
        .trig  (trig_lvl),
        .hyst  (hyst_lvl),
        .rts_n (rts_n)
    );

    // Live status outputs.
    always_comb begin
        trig_hit = (level >= trig_lvl);
        rx_irq   = trig_hit || tmo_req;
        cnt_out  = cnt_show ? level : '0;
    end
endmodule

// File: rtl/rxq_flow_chk.sv
// Property checker for rxq_flow, bound to every instance of it.
// Observes ports and the internal level, threshold and margin.
module rxq_flow_chk #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned CW    = 7
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rx_valid,
    input logic          rd_en,
    input logic          arts_en,
    input logic [CW-1:0] level,
    input logic [CW-1:0] trig_lvl,
    input logic [CW-1:0] hyst_lvl,
    input logic [7:0]    rd_data,
    input logic [2:0]    rd_err,
    input logic          tmo_req,
    input logic          ovr_flag,
    input logic          rts_n
);
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        int'(level) <= int'(DEPTH));

    a_r5_full_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(level) == int'(DEPTH) && rx_valid && !rd_en) |=> int'(level) == int'(DEPTH));

    a_r5_ovr_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_flag) |-> ($past(rx_valid) && int'($past(level)) == int'(DEPTH)));

    a_r6_empty_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && level == '0) |=> ($stable(rd_data) && $stable(rd_err) && level == '0));

    a_r7_tmo_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_req |-> level != '0);

    a_r9_rts_rise_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rts_n) |-> ($past(arts_en) && $past(level) >= $past(trig_lvl)));

    a_r10_rts_fall_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rts_n) && $past(arts_en)) |->
            int'($past(level)) <= int'($past(trig_lvl)) - int'($past(hyst_lvl)));

    a_r11_rts_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        !arts_en |=> !rts_n);
endmodule

bind rxq_flow rxq_flow_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_valid (rx_valid),
    .rd_en    (rd_en),
    .arts_en  (arts_en),
    .level    (level),
    .trig_lvl (trig_lvl),
    .hyst_lvl (hyst_lvl),
    .rd_data  (rd_data),
    .rd_err   (rd_err),
    .tmo_req  (tmo_req),
    .ovr_flag (ovr_flag),
    .rts_n    (rts_n)
);

// File: tb/rxq_flow_test.sv
// Directed bench for rxq_flow: one task per scenario, each self-checking.
module rxq_flow_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic [2:0] rx_err = '0;
    logic       rd_en = 1'b0;
    logic [7:0] rd_data;
    logic [2:0] rd_err;
    logic [1:0] trig_sel = 2'd0;
    logic [1:0] hyst_sel = 2'd0;
    logic       arts_en = 1'b0;
    logic       char_tick = 1'b0;
    logic       cnt_show = 1'b1;
    logic [6:0] cnt_out;
    logic       trig_hit, tmo_req, rx_irq, ovr_flag, rts_n;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rxq_flow uut (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_err(rx_err), .rd_en(rd_en), .rd_data(rd_data), .rd_err(rd_err),
        .trig_sel(trig_sel), .hyst_sel(hyst_sel), .arts_en(arts_en),
        .char_tick(char_tick), .cnt_show(cnt_show), .cnt_out(cnt_out),
        .trig_hit(trig_hit), .tmo_req(tmo_req), .rx_irq(rx_irq),
        .ovr_flag(ovr_flag), .rts_n(rts_n)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic push(input logic [7:0] d, input logic [2:0] e);
        @(negedge clk);
        rx_valid = 1'b1; rx_data = d; rx_err = e;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pop();
        @(negedge clk);
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        char_tick = 1'b1;
        @(negedge clk);
        char_tick = 1'b0;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    task automatic flush();
        while (cnt_out != 0) pop();
    endtask

    task automatic fill_to(input int n);
        while (int'(cnt_out) < n) push(8'h5A, 3'd0);
    endtask

    task automatic t_reset();
        chk("R2 reset level", int'(cnt_out), 0);
        chk("R3 reset trig_hit", int'(trig_hit), 0);
        chk("R7 reset tmo_req", int'(tmo_req), 0);
        chk("R5 reset ovr_flag", int'(ovr_flag), 0);
        chk("R11 reset rts_n", int'(rts_n), 0);
        chk("R1 reset rd_data", int'(rd_data), 0);
    endtask

    task automatic t_order();
        push(8'h11, 3'd1); push(8'h22, 3'd2); push(8'h33, 3'd4);
        chk("R2 level after 3", int'(cnt_out), 3);
        cnt_show = 1'b0;
        settle();
        chk("R2 count hidden", int'(cnt_out), 0);
        cnt_show = 1'b1;
        pop();
        chk("R1 first data", int'(rd_data), 8'h11);
        chk("R1 first err", int'(rd_err), 1);
        pop();
        chk("R1 second data", int'(rd_data), 8'h22);
        chk("R1 second err", int'(rd_err), 2);
        pop();
        chk("R1 third data", int'(rd_data), 8'h33);
        chk("R1 third err", int'(rd_err), 4);
        pop();
        chk("R6 empty read data", int'(rd_data), 8'h33);
        chk("R6 empty read err", int'(rd_err), 4);
        chk("R6 empty read level", int'(cnt_out), 0);
    endtask

    task automatic t_trigger();
        trig_sel = 2'd0;
        fill_to(7);
        chk("R3 below 8", int'(trig_hit), 0);
        chk("R8 irq idle", int'(rx_irq), 0);
        push(8'h01, 3'd0);
        chk("R3 at 8", int'(trig_hit), 1);
        chk("R8 irq on trig", int'(rx_irq), 1);
        pop();
        chk("R4 clears at 7", int'(trig_hit), 0);
        push(8'h02, 3'd0);
        trig_sel = 2'd1;
        settle();
        chk("R3 sel16 at 8", int'(trig_hit), 0);
        fill_to(16);
        chk("R3 at 16", int'(trig_hit), 1);
        trig_sel = 2'd2;
        settle();
        chk("R3 sel56 at 16", int'(trig_hit), 0);
        flush();
    endtask

    task automatic t_rts();
        arts_en = 1'b1;
        trig_sel = 2'd0; hyst_sel = 2'd1;
        fill_to(7); settle();
        chk("R9 below trig", int'(rts_n), 0);
        push(8'h00, 3'd0); settle();
        chk("R9 rises at 8", int'(rts_n), 1);
        pop(); settle();
        chk("R10 held at 7", int'(rts_n), 1);
        pop(); pop(); settle();
        chk("R10 held at 5", int'(rts_n), 1);
        pop(); settle();
        chk("R10 falls at 4", int'(rts_n), 0);
        fill_to(7); settle();
        chk("R10 stays low at 7", int'(rts_n), 0);
        flush();
        trig_sel = 2'd1; hyst_sel = 2'd3;
        fill_to(16); settle();
        chk("R9 rises at 16", int'(rts_n), 1);
        while (cnt_out > 9) pop();
        settle();
        chk("R10 held at 9 hyst8", int'(rts_n), 1);
        pop(); settle();
        chk("R10 falls at 8 hyst8", int'(rts_n), 0);
        flush();
        trig_sel = 2'd0; hyst_sel = 2'd0;
        fill_to(8); settle();
        chk("R9 rises hyst0", int'(rts_n), 1);
        pop(); settle();
        chk("R10 falls at 7 hyst0", int'(rts_n), 0);
        push(8'h00, 3'd0); settle();
        chk("R9 rises again", int'(rts_n), 1);
        arts_en = 1'b0;
        settle();
        chk("R11 disabled low", int'(rts_n), 0);
        flush();
    endtask

    task automatic t_overrun();
        int bad = 0;
        trig_sel = 2'd3;
        for (int i = 0; i < 64; i++) push(8'(i), 3'(i % 8));
        chk("R2 full level", int'(cnt_out), 64);
        chk("R3 at 60 sel3", int'(trig_hit), 1);
        chk("R5 no ovr yet", int'(ovr_flag), 0);
        push(8'hEE, 3'd7);
        chk("R5 ovr set", int'(ovr_flag), 1);
        chk("R5 level kept", int'(cnt_out), 64);
        pop();
        chk("R5 ovr cleared", int'(ovr_flag), 0);
        chk("R1 oldest after full", int'(rd_data), 0);
        for (int i = 1; i < 64; i++) begin
            pop();
            if (rd_data != 8'(i) || rd_err != 3'(i % 8)) bad++;
        end
        chk("R5 drained order mismatches", bad, 0);
        chk("R2 empty after drain", int'(cnt_out), 0);
        pop();
        chk("R5 extra char dropped", int'(rd_data), 63);
    endtask

    task automatic t_timeout();
        trig_sel = 2'd0;
        push(8'hA1, 3'd0);
        tick(); tick(); tick();
        chk("R7 three ticks", int'(tmo_req), 0);
        tick();
        chk("R7 four ticks", int'(tmo_req), 1);
        chk("R8 irq on timeout", int'(rx_irq), 1);
        push(8'hA2, 3'd0);
        chk("R7 cleared by rx", int'(tmo_req), 0);
        tick(); tick(); tick(); tick();
        chk("R7 again after rx", int'(tmo_req), 1);
        pop();
        chk("R7 cleared by read", int'(tmo_req), 0);
        pop();
        tick(); tick(); tick(); tick(); tick();
        chk("R7 empty no request", int'(tmo_req), 0);
        pop();
        tick(); tick(); tick(); tick();
        chk("R7 empty read no request", int'(tmo_req), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        settle();
        t_reset();
        t_order();
        t_trigger();
        t_rts();
        t_overrun();
        t_timeout();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule